// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block sends asynchronous serial frames on a single output line. Software writes a word into a one-entry holding buffer; as soon as the shift stage is idle the word moves across and a frame is sent: a low start bit, the data bits least significant first, an optional parity bit, then one or two high stop bits. The bit period is derived from the block clock through a programmable divider. The data length can be 7, 8 or 9 bits, and parity can be even or odd.

An optional active-low clear-to-send input gates each new frame. It is examined only when a frame would begin, which is at the end of the last stop bit or while idle. When it is high, the line stays high and the bit counter is held. When it drops, the pending frame starts on the next clock edge, without waiting for a bit boundary. A transmit enable gates new frames in the same way. Two flags report whether the holding buffer and the shift stage are empty. A sticky interrupt request is raised either when the buffer empties (cause select 0) or when the shift stage empties (cause select 1), and is cleared by an acknowledge pulse.

The controller has six states. IDLE moves to START on a load. START moves to DATA after one bit period. DATA moves to PARITY, or to STOP1 when parity is off, after the last data bit. PARITY moves to STOP1. STOP1 moves to STOP2 when two stop bits are selected. Otherwise STOP1 ends the frame, and STOP2 always does. An ending frame moves to START when a load is allowed at that edge, or to IDLE when it is not.

Top module: `serial_tx_gated`

## Requirements
- R1: One bit period lasts exactly 16*(n+1) clock cycles, where n is `cfg_div`.
- R2: A frame is sent as a low start bit, then the data bits from bit 0 upward, then parity (if enabled), then stop bits. `cfg_len` selects the data length: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits, 3 = 8 bits.
- R3: The parity bit covers only the configured data bits. It is the XOR of those bits when `cfg_par_odd` = 0, and the inverse of that XOR when `cfg_par_odd` = 1.
- R4: `cfg_two_stop` = 0 sends one high stop bit, and `cfg_two_stop` = 1 sends two.
- R5: A buffered word moves to the shift stage on the first clock edge at which a load is allowed. `buf_empty` becomes 1 at that same edge.
- R6: `sreg_empty` is 0 from the load until the end of the last stop bit. It returns to 1 only if no load follows. If a load follows, it stays 0 and the next start bit begins immediately after the stop bit.
- R7: With `cfg_cts_en` = 1 and `cts_n` high, no new frame starts. `txd` stays high and the buffer keeps its word.
- R8: When `cts_n` falls while a word is pending and the shift stage is idle, the start bit appears after the next clock edge.
- R9: While `tx_en` = 0, no new frame starts.
- R10: With `cfg_irq_sel` = 0, `irq` is set when a word leaves the buffer. With `cfg_irq_sel` = 1, `irq` is set when the shift stage becomes empty.
- R11: `irq` stays set until `irq_ack`. If a set event and an acknowledge fall in the same cycle, `irq` ends up set.
- R12: While idle, `txd` is high. After reset, `txd` = 1, both empty flags are 1 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the divider's count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Divider value n |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_cts_en | input | 1 | Enables clear-to-send gating |
| cfg_irq_sel | input | 1 | Interrupt cause: 0 = buffer empty, 1 = shift stage empty |
| tx_en | input | 1 | Transmit enable |
| wr_valid | input | 1 | Writes `wr_data` into the buffer |
| wr_data | input | 9 | Word to send |
| cts_n | input | 1 | Active-low clear to send |
| irq_ack | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer is empty |
| sreg_empty | output | 1 | Shift stage is idle |
| irq | output | 1 | Sticky interrupt request |

## Verification
Two functions can fall in the same cycle: the interrupt request being set, and an acknowledge clearing it. The bench writes a word with cause select 0 and holds `irq_ack` high across exactly the edge at which the word moves into the shift stage. `irq` must read 1 afterwards. A second pairing is a buffer write made while a frame is in flight. The bench checks that the following start bit begins in the cycle right after the last stop bit, and that `sreg_empty` never rises in between.

// File: rtl/serial_tx_gated_pkg.sv
package serial_tx_gated_pkg;

    localparam int DAT_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } tx_state_t;

    // Index of the final data bit for a length code.
    function automatic logic [3:0] last_bit_idx(input logic [1:0] len);
        unique case (len)
            2'd0:    return 4'd6;
            2'd2:    return 4'd8;
            default: return 4'd7;
        endcase
    endfunction

    // Parity over the configured bits only; odd inverts.
    function automatic logic frame_parity(input logic [DAT_W-1:0] d,
                                          input logic [1:0] len,
                                          input logic odd);
        logic [DAT_W-1:0] mask;
        unique case (len)
            2'd0:    mask = 9'h07F;
            2'd2:    mask = 9'h1FF;
            default: mask = 9'h0FF;
        endcase
        return (^(d & mask)) ^ odd;
    endfunction

endpackage

// File: rtl/tx_pace.sv
module tx_pace #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + $clog2(OVS);

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] cnt_q;

    assign span   = ((CNT_W+1)'(div) + (CNT_W+1)'(1)) * (CNT_W+1)'(OVS);
    assign last_q = CNT_W'(span - (CNT_W+1)'(1));
    assign tick   = !clr && (cnt_q == last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/tx_holdbuf.sv
module tx_holdbuf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr)
                data <= wdata;
            if (wr)
                full <= 1'b1;
            else if (take)
                full <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_irq_flag.sv
module tx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (ack)
            flag <= 1'b0;
    end
endmodule

// File: rtl/serial_tx_gated.sv
module serial_tx_gated
    import serial_tx_gated_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic             cfg_cts_en,
    input  logic             cfg_irq_sel,
    input  logic             tx_en,
    input  logic             wr_valid,
    input  logic [8:0]       wr_data,
    input  logic             cts_n,
    input  logic             irq_ack,
    output logic             txd,
    output logic             buf_empty,
    output logic             sreg_empty,
    output logic             irq
);
    tx_state_t        state_q, state_d;
    logic [DAT_W-1:0] sh_q;
    logic [3:0]       idx_q;
    logic             par_q;

    logic             tick;
    logic             buf_full;
    logic [DAT_W-1:0] buf_data;
    logic             cts_ok, may_load, frame_end, load, irq_set;

    assign cts_ok    = !cfg_cts_en || !cts_n;
    assign may_load  = tx_en && buf_full && cts_ok;
    assign frame_end = tick && ((state_q == ST_STOP1 && !cfg_two_stop) ||
                                 state_q == ST_STOP2);
    assign load      = may_load && (state_q == ST_IDLE || frame_end);
    assign irq_set   = cfg_irq_sel ? (frame_end && !load) : load;

    tx_pace #(.DIV_W(DIV_W), .OVS(OVS)) u_pace (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == ST_IDLE),
        .div  (cfg_div),
        .tick (tick)
    );

    tx_holdbuf #(.W(DAT_W)) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr_valid),
        .wdata(wr_data),
        .take (load),
        .full (buf_full),
        .data (buf_data)
    );

    tx_irq_flag u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (irq_set),
        .ack  (irq_ack),
        .flag (irq)
    );

    // State register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            idx_q   <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                sh_q  <= buf_data;
                idx_q <= '0;
                par_q <= frame_parity(buf_data, cfg_len, cfg_par_odd);
            end else if (state_q == ST_DATA && tick) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 4'd1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_START;
            ST_START: if (tick) state_d = ST_DATA;
            ST_DATA:
                if (tick && idx_q == last_bit_idx(cfg_len))
                    state_d = cfg_par_en ? ST_PAR : ST_STOP1;
            ST_PAR:   if (tick) state_d = ST_STOP1;
            ST_STOP1:
                if (tick) begin
                    if (cfg_two_stop) state_d = ST_STOP2;
                    else              state_d = load ? ST_START : ST_IDLE;
                end
            ST_STOP2: if (tick) state_d = load ? ST_START : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sh_q[0];
            ST_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
        sreg_empty = (state_q == ST_IDLE);
        buf_empty  = !buf_full;
    end
endmodule

// File: rtl/serial_tx_gated_chk.sv
module serial_tx_gated_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cts_en,
    input logic cts_n,
    input logic tx_en,
    input logic irq_ack,
    input logic txd,
    input logic buf_empty,
    input logic sreg_empty,
    input logic irq
);
    a_r12_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        sreg_empty |-> txd);

    a_r7_cts_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_en && cts_n && sreg_empty) |=> sreg_empty);

    a_r9_disable_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && sreg_empty) |=> sreg_empty);

    a_r11_request_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    a_r5_buffer_moves_to_shifter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !sreg_empty);

    a_r2_frame_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sreg_empty) |-> !txd);
endmodule

bind serial_tx_gated serial_tx_gated_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_cts_en(cfg_cts_en),
    .cts_n     (cts_n),
    .tx_en     (tx_en),
    .irq_ack   (irq_ack),
    .txd       (txd),
    .buf_empty (buf_empty),
    .sreg_empty(sreg_empty),
    .irq       (irq)
);

// File: tb/serial_tx_gated_test.sv
module serial_tx_gated_test;

    typedef struct packed {
        logic [7:0] div;
        logic [1:0] len;
        logic       pe;
        logic       odd;
        logic       two;
        logic [8:0] data;
        logic       xpar;
        logic [3:0] nbits;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        {8'd0, 2'd1, 1'b1, 1'b0, 1'b0, 9'h0A5, 1'b0, 4'd11},
        {8'd1, 2'd1, 1'b1, 1'b1, 1'b0, 9'h0A5, 1'b1, 4'd11},
        {8'd0, 2'd2, 1'b0, 1'b0, 1'b1, 9'h155, 1'b0, 4'd12},
        {8'd0, 2'd0, 1'b1, 1'b0, 1'b0, 9'h180, 1'b0, 4'd10},
        {8'd2, 2'd2, 1'b1, 1'b1, 1'b1, 9'h101, 1'b1, 4'd13},
        {8'd0, 2'd1, 1'b0, 1'b0, 1'b0, 9'h03C, 1'b0, 4'd10}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_div;
    logic [1:0] cfg_len;
    logic       cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_cts_en, cfg_irq_sel;
    logic       tx_en, wr_valid, cts_n, irq_ack;
    logic [8:0] wr_data;
    logic       txd, buf_empty, sreg_empty, irq;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    serial_tx_gated uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_cts_en(cfg_cts_en),
        .cfg_irq_sel(cfg_irq_sel), .tx_en(tx_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .cts_n(cts_n), .irq_ack(irq_ack), .txd(txd),
        .buf_empty(buf_empty), .sreg_empty(sreg_empty), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic put(input logic [8:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        step(1);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (!sreg_empty && guard < 20000) begin
            step(1);
            guard++;
        end
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_div = 8'd0; cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        cfg_two_stop = 1'b0; cfg_cts_en = 1'b0; cfg_irq_sel = 1'b0;
        tx_en = 1'b1; wr_valid = 1'b0; wr_data = '0; cts_n = 1'b1; irq_ack = 1'b0;
        @(posedge clk);
        #1;
        step(2);
        rst_n = 1'b1;
        step(1);

        // Reset state (R12)
        check("R12 reset txd", int'(txd), 1);
        check("R12 reset buf_empty", int'(buf_empty), 1);
        check("R12 reset sreg_empty", int'(sreg_empty), 1);
        check("R12 reset irq", int'(irq), 0);

        // Vector table: frame contents for several settings (R1 R2 R3 R4)
        for (int i = 0; i < NV; i++) begin
            logic [15:0] got, exp;
            int per, nd;
            cfg_div = VEC[i].div; cfg_len = VEC[i].len; cfg_par_en = VEC[i].pe;
            cfg_par_odd = VEC[i].odd; cfg_two_stop = VEC[i].two; cfg_irq_sel = 1'b0;
            per = 16 * (int'(VEC[i].div) + 1);
            nd  = (VEC[i].len == 2'd0) ? 7 : (VEC[i].len == 2'd2) ? 9 : 8;
            ack_pulse();
            check("R11 ack clears irq", int'(irq), 0);
            put(VEC[i].data);
            step(1);
            check("R5 buffer emptied at load", int'(buf_empty), 1);
            check("R6 shift stage busy", int'(sreg_empty), 0);
            check("R10 irq on buffer empty", int'(irq), 1);
            got = '0;
            exp = '1;
            for (int k = 0; k < 16; k++) begin
                if (k == 0)                         exp[k] = 1'b0;
                else if (k <= nd)                   exp[k] = VEC[i].data[k-1];
                else if (VEC[i].pe && k == nd + 1)  exp[k] = VEC[i].xpar;
            end
            step(per / 2);
            got[0] = txd;
            for (int k = 1; k < int'(VEC[i].nbits); k++) begin
                step(per);
                got[k] = txd;
            end
            for (int k = int'(VEC[i].nbits); k < 16; k++) got[k] = 1'b1;
            check("R1 R2 R3 R4 frame bits", int'(got), int'(exp));
            step(per / 2 + 2);
            check("R6 shift stage empty after stop", int'(sreg_empty), 1);
            check("R12 idle line high", int'(txd), 1);
            check("R11 irq held without ack", int'(irq), 1);
        end

        // R1: start bit width with n=3
        begin
            int cnt = 0;
            cfg_div = 8'd3; cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
            put(9'h001);
            step(1);
            while (!txd && cnt < 1000) begin
                cnt++;
                step(1);
            end
            check("R1 start bit cycles", cnt, 64);
            wait_idle();
        end

        // R7 / R8: CTS holds then releases immediately
        cfg_div = 8'd0; cfg_cts_en = 1'b1; cts_n = 1'b1;
        put(9'h055);
        step(40);
        check("R7 no start while cts high", int'(sreg_empty), 1);
        check("R7 line high", int'(txd), 1);
        check("R7 word kept", int'(buf_empty), 0);
        cts_n = 1'b0;
        step(1);
        check("R8 immediate start on cts low", int'(txd), 0);
        wait_idle();

        // R7 at stop boundary: second word held when cts rises mid-frame
        put(9'h0F0);
        step(1);
        put(9'h00F);
        cts_n = 1'b1;
        step(200);
        check("R7 stop-boundary hold sreg", int'(sreg_empty), 1);
        check("R7 stop-boundary hold buf", int'(buf_empty), 0);
        cts_n = 1'b0;
        step(1);
        check("R8 resume start", int'(txd), 0);
        wait_idle();
        cfg_cts_en = 1'b0;

        // R6: back-to-back frames, no idle gap
        begin
            logic seen_idle = 1'b0;
            put(9'h0AA);
            step(1);
            put(9'h033);
            repeat (158) begin
                step(1);
                if (sreg_empty) seen_idle = 1'b1;
            end
            step(1);
            check("R6 no idle between frames", int'(seen_idle), 0);
            check("R6 next start follows stop", int'(txd), 0);
            check("R6 second word loaded", int'(buf_empty), 1);
            wait_idle();
        end

        // R9: transmit enable off
        tx_en = 1'b0;
        put(9'h011);
        step(50);
        check("R9 no start when disabled", int'(sreg_empty), 1);
        check("R9 word kept", int'(buf_empty), 0);
        tx_en = 1'b1;
        step(1);
        check("R9 starts once enabled", int'(txd), 0);
        wait_idle();

        // R10: cause select 1
        cfg_irq_sel = 1'b1;
        ack_pulse();
        put(9'h022);
        step(1);
        check("R10 no irq at load with sel1", int'(irq), 0);
        wait_idle();
        check("R10 irq at shift empty", int'(irq), 1);
        ack_pulse();
        check("R11 ack clears", int'(irq), 0);

        // R11: set and ack in the same cycle
        cfg_irq_sel = 1'b0;
        wr_valid = 1'b1;
        wr_data  = 9'h044;
        step(1);
        wr_valid = 1'b0;
        irq_ack  = 1'b1;
        step(1);
        irq_ack  = 1'b0;
        check("R11 set wins over ack", int'(irq), 1);
        wait_idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule